// File: doc/BRIEF.md
# SMRAM and TSEG access controller

This block holds the two control registers that govern system-management memory and a third register that reports an extended TSEG size. From their contents it decides, for every access address and the current system-management-mode (SMM) flag, where the access goes. The possible targets are main RAM, the PCI side, or a blackhole that returns all-ones on reads and drops writes. The decision is combinational from the address and mode inputs and the register state. Register writes take effect at the next clock edge.

Three windows are governed. The first is the legacy video window 0xA0000–0xBFFFF. The second is a 128 KB high alias at 0xFEDA0000–0xFEDBFFFF, which reaches RAM offset 0xA0000. The third is the TSEG region just below the top of low memory. All other addresses below the top of low memory go to RAM, and everything above it goes to PCI. A one-way lock freezes the protected fields until reset.

Top module: `smram_guard`

## Requirements
- R1: After reset, the readback is 0x02 for the mode register (cfg_sel=0), 0x38 for the TSEG register (cfg_sel=1) and 0xFFFF for the extended-size register (cfg_sel=2). cfg_sel=3 always reads 0.
- R2: While unlocked, only bits 6 (open), 4 (lock) and 3 (global enable) of the mode register can be written. In the TSEG register, only bit 7 (high enable), bits [2:1] (size) and bit 0 (TSEG enable) can be written. All other bits keep their reset values.
- R3: A write that leaves the lock bit set also clears the open bit. From then until reset, writes to the mode and TSEG registers change nothing.
- R4: Outside SMM, when open is set, the legacy window goes to PCI if high enable is set and to RAM otherwise, and the high alias goes to RAM if high enable is set and to PCI otherwise. When open is clear, both windows go to PCI.
- R5: In SMM with global enable set, the legacy window goes to RAM when high enable is clear, and the high alias goes to RAM when high enable is set. A window not granted this way, or any window when global enable is clear, is routed as in R4.
- R6: With TSEG enabled, size codes 00, 01, 10 and 11 give 1 MB, 2 MB, 8 MB and EXT_MB megabytes. The region is [LOW_TOP − size, LOW_TOP). With TSEG disabled the size is zero.
- R7: Outside SMM, TSEG accesses route to blackhole (route=2'b10) with rd_data=0xFFFFFFFF. In SMM they route to RAM.
- R8: Writing 0xFFFF to the extended-size register replaces its contents with EXT_MB when EXT_MB is nonzero. Writes of any other value leave it unchanged.
- R9: Route encoding is 2'b00 RAM, 2'b01 PCI, 2'b10 blackhole. Addresses outside the three windows go to RAM below LOW_TOP and to PCI at or above it. rd_data is 0 unless the route is blackhole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 mode, 1 TSEG, 2 extended size |
| cfg_wdata | input | 16 | Write data (low byte for the 8-bit registers) |
| cfg_rdata | output | 16 | Readback of the selected register |
| acc_addr | input | 32 | Access address |
| acc_smm | input | 1 | Access is made in system-management mode |
| route | output | 2 | Routing decision |
| rd_data | output | 32 | Read data for blackholed reads |

## Verification
The bench targets the same-write case where lock and open are set together. A design that clears open only on a later cycle would leave the legacy window reachable from RAM for one cycle. After locking, the bench retries every writable field. A wrong locked mask would let a privileged field change.

It probes the first and last byte of each window and of TSEG under every size code. An off-by-one base would misroute the edge byte, and a size code mapped wrongly would shift the base by megabytes. The bench also exercises global enable with high enable both ways in and out of SMM, where swapped low and high grants would show as RAM on the wrong window.

// File: rtl/smram_guard.sv
module smram_guard #(
  parameter logic [31:0] LOW_TOP = 32'h8000_0000,
  parameter int unsigned EXT_MB  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  input  logic [31:0] acc_addr,
  input  logic        acc_smm,
  output logic [1:0]  route,
  output logic [31:0] rd_data
);
  localparam logic [1:0] RT_RAM = 2'b00, RT_PCI = 2'b01, RT_BH = 2'b10;
  localparam logic [7:0] MODE_RST = 8'h02, TSEG_RST = 8'h38;
  localparam logic [7:0] MODE_WM = 8'h58, TSEG_WM = 8'h87;
  localparam logic [15:0] QUERY = 16'hFFFF;
  localparam logic [31:0] MB = 32'h0010_0000;

  logic [7:0]  mode_q, tseg_q, mode_d;
  logic [15:0] ext_q;
  logic        locked;

  assign locked = mode_q[4];
  assign mode_d = (mode_q & ~MODE_WM) | (cfg_wdata[7:0] & MODE_WM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      tseg_q <= TSEG_RST;
      ext_q  <= QUERY;
    end else if (cfg_we) begin
      if (cfg_sel == 2'd0 && !locked)
        mode_q <= mode_d[4] ? (mode_d & 8'hBF) : mode_d;
      if (cfg_sel == 2'd1 && !locked)
        tseg_q <= (tseg_q & ~TSEG_WM) | (cfg_wdata[7:0] & TSEG_WM);
      if (cfg_sel == 2'd2 && cfg_wdata == QUERY && EXT_MB != 0)
        ext_q <= 16'(EXT_MB);
    end
  end

  always_comb begin
    case (cfg_sel)
      2'd0: cfg_rdata = {8'h00, mode_q};
      2'd1: cfg_rdata = {8'h00, tseg_q};
      2'd2: cfg_rdata = ext_q;
      default: cfg_rdata = 16'h0000;
    endcase
  end

  logic        open_b, gen, hen;
  logic [31:0] tseg_sz, tseg_base;
  logic        in_leg, in_alias, in_tseg;

  assign open_b = mode_q[6];
  assign gen    = mode_q[3];
  assign hen    = tseg_q[7];

  always_comb begin
    case (tseg_q[2:1])
      2'b00:   tseg_sz = MB;
      2'b01:   tseg_sz = MB << 1;
      2'b10:   tseg_sz = MB << 3;
      default: tseg_sz = 32'(EXT_MB) << 20;
    endcase
    if (!tseg_q[0]) tseg_sz = 32'h0;
  end

  assign tseg_base = LOW_TOP - tseg_sz;
  assign in_leg    = acc_addr >= 32'h000A_0000 && acc_addr <= 32'h000B_FFFF;
  assign in_alias  = acc_addr >= 32'hFEDA_0000 && acc_addr <= 32'hFEDB_FFFF;
  assign in_tseg   = tseg_sz != 0 && acc_addr >= tseg_base && acc_addr < LOW_TOP;

  always_comb begin
    if (in_leg) begin
      if (acc_smm && gen && !hen) route = RT_RAM;
      else if (open_b && !hen)    route = RT_RAM;
      else                        route = RT_PCI;
    end else if (in_alias) begin
      if (acc_smm && gen && hen)  route = RT_RAM;
      else if (open_b && hen)     route = RT_RAM;
      else                        route = RT_PCI;
    end else if (in_tseg) begin
      route = acc_smm ? RT_RAM : RT_BH;
    end else begin
      route = (acc_addr < LOW_TOP) ? RT_RAM : RT_PCI;
    end
  end

  assign rd_data = (route == RT_BH) ? 32'hFFFF_FFFF : 32'h0;

  assert_lock_clears_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[4] |-> !mode_q[6]);
  assert_lock_freezes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[4] |=> ($stable(mode_q) && $stable(tseg_q)));
  assert_blackhole_not_smm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (route == RT_BH) |-> !acc_smm);
  assert_ones_only_bh_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data != 32'h0) |-> (route == RT_BH && acc_addr < LOW_TOP));
  assert_ext_values_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_q != QUERY) |-> (ext_q == 16'(EXT_MB)));
  assert_closed_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[6] && !acc_smm && in_alias) |-> route == RT_PCI);
  assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[2:0] == 3'b010 && tseg_q[6:3] == 4'b0111));
endmodule

// File: tb/sim_smram_guard.sv
`timescale 1ns/1ps
module sim_smram_guard;
  localparam logic [31:0] TOP = 32'h8000_0000;
  localparam int EXTM = 16;

  logic clk = 0, rst_n = 0, cfg_we = 0, acc_smm = 0;
  logic [1:0] cfg_sel = 0;
  logic [15:0] cfg_wdata = 0;
  logic [31:0] acc_addr = 0;
  logic [15:0] cfg_rdata;
  logic [1:0] route;
  logic [31:0] rd_data;
  int compared = 0, mismatched = 0;
  string req = "R1";
  bit done = 0;

  smram_guard #(.LOW_TOP(TOP), .EXT_MB(EXTM)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_addr(acc_addr),
    .acc_smm(acc_smm), .route(route), .rd_data(rd_data));

  always #4 clk = ~clk;

  // reference state
  int m_mode, m_tseg, m_ext;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 2; m_tseg = 56; m_ext = 65535;
    end else if (cfg_we) begin
      int v;
      v = cfg_wdata & 255;
      if (cfg_sel == 0 && (m_mode / 16) % 2 == 0) begin
        m_mode = 2;
        if ((v / 64) % 2 == 1) m_mode += 64;
        if ((v / 16) % 2 == 1) m_mode += 16;
        if ((v / 8) % 2 == 1)  m_mode += 8;
        if (m_mode >= 80) m_mode -= 64;
      end else if (cfg_sel == 1 && (m_mode / 16) % 2 == 0) begin
        m_tseg = 56 + (v % 8);
        if (v >= 128) m_tseg += 128;
      end else if (cfg_sel == 2 && cfg_wdata == 16'hFFFF && EXTM > 0) begin
        m_ext = EXTM;
      end
    end
  end

  function automatic int exp_route(longint a, bit smm);
    bit op, g, h;
    longint sz, mbytes;
    op = (m_mode / 64) % 2; g = (m_mode / 8) % 2; h = m_tseg >= 128;
    case ((m_tseg / 2) % 4)
      0: mbytes = 1; 1: mbytes = 2; 2: mbytes = 8; default: mbytes = EXTM;
    endcase
    sz = (m_tseg % 2 == 1) ? mbytes * 1048576 : 0;
    if (a >= 'hA0000 && a < 'hC0000)
      return ((smm && g && !h) || (op && !h)) ? 0 : 1;
    if (a >= 'hFEDA0000 && a < 'hFEDC0000)
      return ((smm && g && h) || (op && h)) ? 0 : 1;
    if (sz > 0 && a >= longint'(TOP) - sz && a < longint'(TOP))
      return smm ? 0 : 2;
    return (a < longint'(TOP)) ? 0 : 1;
  endfunction

  always @(negedge clk) if (!done) begin
    int er, ec;
    longint ed;
    er = exp_route(longint'(acc_addr), acc_smm);
    ed = (er == 2) ? 'hFFFFFFFF : 0;
    case (cfg_sel)
      0: ec = m_mode; 1: ec = m_tseg; 2: ec = m_ext; default: ec = 0;
    endcase
    compared += 3;
    if (int'(route) != er) begin
      mismatched++;
      $display("FAIL %s route addr=%h smm=%0d actual=%0d expected=%0d", req, acc_addr, acc_smm, route, er);
    end
    if (longint'(rd_data) != ed) begin
      mismatched++;
      $display("FAIL %s rd_data actual=%h expected=%h", req, rd_data, ed);
    end
    if (int'(cfg_rdata) != ec) begin
      mismatched++;
      $display("FAIL %s cfg_rdata sel=%0d actual=%h expected=%h", req, cfg_sel, cfg_rdata, ec);
    end
  end

  task automatic go(input string r);
    req = r;
    @(negedge clk); #2;
  endtask

  task automatic wr(input string r, input logic [1:0] s, input logic [15:0] d);
    cfg_sel = s; cfg_wdata = d; cfg_we = 1; go(r);
    cfg_we = 0; go(r);
  endtask

  task automatic probe(input string r, input logic [31:0] a);
    for (int sm = 0; sm < 2; sm++) begin
      acc_addr = a; acc_smm = sm[0];
      for (int s = 0; s < 4; s++) begin cfg_sel = s[1:0]; go(r); end
    end
  endtask

  task automatic sweep(input string r);
    probe(r, 32'h000A_0000); probe(r, 32'h000B_FFFF);
    probe(r, 32'h0009_FFFF); probe(r, 32'h000C_0000);
    probe(r, 32'hFEDA_0000); probe(r, 32'hFEDB_FFFF); probe(r, 32'hFEDC_0000);
    probe(r, TOP - 32'h0010_0000); probe(r, TOP - 32'h0020_0000);
    probe(r, TOP - 32'h0080_0000); probe(r, TOP - 32'h0100_0000);
    probe(r, TOP - 32'h0100_0001); probe(r, TOP - 1); probe(r, TOP);
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    go("R1"); go("R1");
    rst_n = 1;
    probe("R1", 32'h0000_1000);
    sweep("R9");
    wr("R2", 2'd1, 16'hFFFF);
    wr("R2", 2'd0, 16'hFFAF);
    sweep("R4");
    for (int m = 0; m < 4; m++) begin
      wr("R5", 2'd0, m[0] ? 16'h0048 : 16'h0008);
      for (int t = 0; t < 8; t++) begin
        wr("R6", 2'd1, {8'h00, t[2] ? 8'h80 : 8'h00} | 16'(t % 4 * 2 + 1));
        sweep("R7");
      end
      wr("R5", 2'd1, m[1] ? 16'h0080 : 16'h0000);
      sweep("R5");
    end
    wr("R8", 2'd2, 16'h1234);
    wr("R8", 2'd2, 16'hFFFF);
    wr("R8", 2'd2, 16'h0001);
    wr("R6", 2'd1, 16'h0007);
    sweep("R6");
    wr("R3", 2'd0, 16'h0058);
    sweep("R3");
    wr("R3", 2'd0, 16'h0048);
    wr("R3", 2'd1, 16'h0080);
    wr("R3", 2'd0, 16'h0000);
    sweep("R3");
    rst_n = 0; go("R1"); rst_n = 1;
    probe("R1", 32'h000A_0000);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule